// File: doc/BRIEF.md
# Two-Part Inter-Frame Deferral Controller

This block decides when a half-duplex Ethernet MAC may start a frame. Once the medium goes quiet, it counts out the inter-packet gap. Counting advances on a one-cycle bit-time tick. The gap has two parts:

- In the first part, renewed carrier sense restarts the count.
- In the second part, carrier is ignored. A pending frame therefore leaves as soon as the full gap has run out, even if a receive has just begun.

After one of the MAC's own transmissions the gap starts only once both transmitting and carrier are low. For the first bit times of that gap, carrier is masked, so that the transceiver's post-transmit echo is not taken as traffic.

When a transmission collides, the block does not stop at once. It lets the 64-bit preamble finish and then holds a 32-bit jam phase. At the end of the jam it raises a one-cycle request to the external backoff logic.

The total gap and the first-part length are both programmable. They are captured each time a gap starts, and a disable input collapses the scheme to a single fully resettable gap.

Top module: `txdefer_ctl`

## Requirements
- R1: After reset, `tx_go`, `jam_on` and `backoff_req` are low. No `tx_go` occurs while the medium has not yet been idle for a gap.
- R2: When `crs` and `tx_busy` are low, the gap timer starts. With `tx_pend` high, `tx_go` rises after exactly `gap_len` further bit ticks (default 96). Cycles without a tick do not count.
- R3: While the gap count is below the first-part length (default 60), asserted carrier holds the count at zero. The full gap is then timed again from the last tick at which carrier was high.
- R4: Once the count has reached the first-part length, carrier no longer affects it. A pending frame gets `tx_go` when the full gap expires, even with carrier high.
- R5: With `two_part_off` = 1, `part1_len` is ignored and carrier restarts the gap anywhere in it. The gap length is still `gap_len`.
- R6: If `part1_len` >= `gap_len`, the first part is clamped to `gap_len`, so the whole gap is resettable.
- R7: In a gap that follows the block's own transmission, carrier is ignored while the count is below 40. From count 40 up to the first-part limit, carrier restarts the gap as in R3.
- R8: A collision seen during a transmission starts the jam phase. `jam_on` rises after the 64th bit tick following `tx_go`, once the preamble is complete. `jam_on` lasts 32 ticks. `backoff_req` is a one-cycle pulse on the 32nd jam tick, and `jam_on` falls with it.
- R9: `gap_len` and `part1_len` are sampled when a gap starts. Changing them mid-gap does not alter that gap, but the next gap uses the new value.
- R10: `tx_go` is a one-cycle pulse. After it, no new gap starts until `tx_busy` has been seen high and then low.
- R11: If the gap expires with nothing pending, the block waits in a ready condition. A request that then arrives with carrier low gets `tx_go` in the same cycle. Carrier seen while ready cancels the ready condition, and a new full gap is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bit_tick | input | 1 | one-cycle pulse per bit time |
| crs | input | 1 | carrier sense |
| tx_pend | input | 1 | a frame is waiting to be sent |
| tx_busy | input | 1 | serializer is transmitting |
| col | input | 1 | collision detected |
| gap_len | input | CW | total gap in bit times |
| part1_len | input | CW | resettable first part in bit times |
| two_part_off | input | 1 | 1 = single resettable gap |
| tx_go | output | 1 | start-of-transmit strobe |
| jam_on | output | 1 | jam phase in progress |
| backoff_req | output | 1 | jam finished, start backoff |

## Verification
A wrong gap count, first-part limit or blinding flag shows up as a `tx_go` edge on the wrong bit tick. It is seen on the first frame after the fault, at most one gap length (255 ticks) later. The bench therefore timestamps every `tx_go` and `backoff_req` in bit ticks and compares each against a queue of expected events. A stale `jam_on` or a leaked strobe either shifts a queued timestamp or appears as an event no one expected. Mid-gap parameter changes, carrier placed on both sides of the first-part and blinding limits, and sparse ticks are what separate a correct counter from an off-by-one.

// File: rtl/txdefer_ctl.sv
module txdefer_ctl #(
  parameter int CW         = 8,
  parameter int PRE_BITS   = 64,
  parameter int JAM_BITS   = 32,
  parameter int BLIND_BITS = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          crs,
  input  logic          tx_pend,
  input  logic          tx_busy,
  input  logic          col,
  input  logic [CW-1:0] gap_len,
  input  logic [CW-1:0] part1_len,
  input  logic          two_part_off,
  output logic          tx_go,
  output logic          jam_on,
  output logic          backoff_req
);

  localparam int PW = $clog2(PRE_BITS + 1);
  localparam int JW = $clog2(JAM_BITS);
  localparam logic [CW-1:0] BLIND_C = CW'(BLIND_BITS);
  localparam logic [PW-1:0] PRE_C   = PW'(PRE_BITS);
  localparam logic [PW-1:0] PRE_M1  = PW'(PRE_BITS - 1);
  localparam logic [JW-1:0] JAM_M1  = JW'(JAM_BITS - 1);

  typedef enum logic [2:0] {S_WAIT, S_GAP, S_READY, S_TX, S_JAM} st_t;

  st_t           st;
  logic [CW-1:0] cnt, gap_q, p1_q;
  logic          post_tx, need_busy, col_q;
  logic [PW-1:0] pcnt;
  logic [JW-1:0] jcnt;

  logic [CW-1:0] p1_in;
  logic          blind, gap_done, part1_hit, pre_end;

  assign p1_in     = (two_part_off || part1_len >= gap_len) ? gap_len : part1_len;
  assign blind     = post_tx && (cnt < BLIND_C);
  assign gap_done  = (st == S_GAP) && (cnt >= gap_q);
  assign part1_hit = crs && !blind && (cnt < p1_q);
  assign pre_end   = (pcnt == PRE_C) || (bit_tick && pcnt == PRE_M1);

  assign tx_go       = tx_pend && (gap_done || (st == S_READY && !crs));
  assign jam_on      = (st == S_JAM);
  assign backoff_req = (st == S_JAM) && bit_tick && (jcnt == JAM_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      cnt       <= '0;
      gap_q     <= '0;
      p1_q      <= '0;
      post_tx   <= 1'b0;
      need_busy <= 1'b0;
      col_q     <= 1'b0;
      pcnt      <= '0;
      jcnt      <= '0;
    end else begin
      case (st)
        S_WAIT: begin
          if (!need_busy && !tx_busy && !crs) begin
            st    <= S_GAP;
            cnt   <= '0;
            gap_q <= gap_len;
            p1_q  <= p1_in;
          end
        end
        S_GAP: begin
          if (tx_go) begin
            st        <= S_TX;
            need_busy <= 1'b1;
            col_q     <= 1'b0;
            pcnt      <= '0;
            post_tx   <= 1'b0;
          end else if (gap_done) begin
            st      <= S_READY;
            post_tx <= 1'b0;
          end else if (part1_hit) begin
            cnt     <= '0;
            post_tx <= 1'b0;
          end else if (bit_tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_READY: begin
          if (tx_go) begin
            st        <= S_TX;
            need_busy <= 1'b1;
            col_q     <= 1'b0;
            pcnt      <= '0;
          end else if (crs) begin
            st <= S_WAIT;
          end
        end
        S_TX: begin
          if (tx_busy) need_busy <= 1'b0;
          if (col) col_q <= 1'b1;
          if (bit_tick && pcnt != PRE_C) pcnt <= pcnt + 1'b1;
          if ((col || col_q) && pre_end) begin
            st   <= S_JAM;
            jcnt <= '0;
          end else if (!need_busy && !tx_busy) begin
            st      <= S_WAIT;
            post_tx <= 1'b1;
          end
        end
        S_JAM: begin
          if (tx_busy) need_busy <= 1'b0;
          if (bit_tick) begin
            jcnt <= jcnt + 1'b1;
            if (jcnt == JAM_M1) begin
              st      <= S_WAIT;
              post_tx <= 1'b1;
              col_q   <= 1'b0;
            end
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_GAP |-> cnt <= gap_q); // R2

  AST_PART2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && cnt >= p1_q && cnt < gap_q) |=> (st == S_GAP && cnt >= $past(cnt))); // R4

  AST_BLIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && post_tx && cnt < BLIND_C && cnt < gap_q) |=> (st == S_GAP && cnt >= $past(cnt))); // R7

  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_GAP |=> (st != S_GAP || ($stable(gap_q) && $stable(p1_q)))); // R9

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go); // R10

  AST_TX_WAITS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && need_busy) |=> (st == S_TX || st == S_JAM)); // R10

  AST_JAM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_req |=> !jam_on); // R8

endmodule

// File: tb/txdefer_ctl_bench.sv
module txdefer_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, crs = 1'b1, tx_pend = 1'b1, tx_busy = 1'b0, col = 1'b0;
  logic [7:0] gap_len = 8'd96, part1_len = 8'd60;
  logic two_part_off = 1'b0;
  logic tx_go, jam_on, backoff_req;

  always #5 clk = ~clk;

  txdefer_ctl u_txdefer_ctl (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .crs(crs), .tx_pend(tx_pend),
    .tx_busy(tx_busy), .col(col), .gap_len(gap_len), .part1_len(part1_len),
    .two_part_off(two_part_off), .tx_go(tx_go), .jam_on(jam_on), .backoff_req(backoff_req)
  );

  int checks = 0, fails = 0;
  int tcnt = 0, mon_t = 0, tdiv = 1, ph = 0;
  int qk[$];
  int qa[$];
  string qr[$];
  bit done = 0;

  task automatic push_ev(string req, int kind, int at);
    qr.push_back(req); qk.push_back(kind); qa.push_back(at);
  endtask

  always @(posedge clk) begin
    if (rst_n && (tx_go || backoff_req)) begin
      int k;
      k = tx_go ? 0 : 1;
      checks++;
      if (qk.size() == 0) begin
        fails++;
        $display("FAIL unexpected event: got kind %0d at tick %0d, expected none", k, mon_t);
      end else begin
        string r;
        int ek, ea;
        r = qr.pop_front(); ek = qk.pop_front(); ea = qa.pop_front();
        if (ek != k || ea != mon_t) begin
          fails++;
          $display("FAIL %s: got kind %0d at tick %0d, expected kind %0d at tick %0d", r, k, mon_t, ek, ea);
        end
      end
    end
    if (bit_tick) mon_t++;
  end

  task automatic cyc();
    ph = (ph + 1) % tdiv;
    bit_tick = (ph == 0);
    @(posedge clk);
    if (bit_tick) tcnt++;
    @(negedge clk);
  endtask

  task automatic run_to(int t);
    while (tcnt < t) cyc();
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b, expected %b", req, act, exp);
    end
  endtask

  task automatic expect_go(string req, int at);
    push_ev(req, 0, at);
    run_to(at);
    cyc();
  endtask

  task automatic finish_tx(output int base);
    tx_pend = 1'b0; tx_busy = 1'b1;
    repeat (4) cyc();
    tx_busy = 1'b0; crs = 1'b0;
    cyc(); cyc();
    base = tcnt;
  endtask

  task automatic fresh(input logic [7:0] gl, input logic [7:0] p1, input logic dis,
                       input logic pend, output int base);
    tx_pend = 1'b0; crs = 1'b0;
    run_to(tcnt + 260);
    crs = 1'b1; cyc(); cyc();
    gap_len = gl; part1_len = p1; two_part_off = dis; tx_pend = pend;
    crs = 1'b0; cyc();
    base = tcnt;
  endtask

  initial begin
    int b, b2, th, eg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    check_bit("R1 tx_go after reset", tx_go, 1'b0);
    check_bit("R1 jam_on after reset", jam_on, 1'b0);
    check_bit("R1 backoff_req after reset", backoff_req, 1'b0);
    repeat (50) cyc();

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    expect_go("R2 default gap", b + 96);
    finish_tx(b2);

    tdiv = 3;
    fresh(8'd20, 8'd10, 1'b0, 1'b1, b);
    expect_go("R2 sparse ticks", b + 20);
    finish_tx(b2);
    tdiv = 1;

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    run_to(b + 30); crs = 1'b1; repeat (5) cyc(); crs = 1'b0; th = tcnt;
    expect_go("R3 part1 restart", th + 96);
    finish_tx(b2);

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    run_to(b + 70); crs = 1'b1;
    expect_go("R4 part2 ignores carrier", b + 96);
    finish_tx(b2);

    fresh(8'd96, 8'd60, 1'b1, 1'b1, b);
    run_to(b + 80); crs = 1'b1; repeat (3) cyc(); crs = 1'b0; th = tcnt;
    expect_go("R5 disabled two-part", th + 96);
    finish_tx(b2);

    fresh(8'd50, 8'd200, 1'b0, 1'b1, b);
    run_to(b + 45); crs = 1'b1; repeat (3) cyc(); crs = 1'b0; th = tcnt;
    expect_go("R6 clamped part1", th + 50);
    finish_tx(b2);

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    expect_go("R2 before blinding", b + 96);
    finish_tx(b2);
    tx_pend = 1'b1;
    run_to(b2 + 10); crs = 1'b1; repeat (10) cyc(); crs = 1'b0;
    expect_go("R7 blinding", b2 + 96);
    finish_tx(b2);
    tx_pend = 1'b1;
    run_to(b2 + 45); crs = 1'b1; repeat (3) cyc(); crs = 1'b0; th = tcnt;
    expect_go("R7 after blinding", th + 96);
    finish_tx(b2);

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    run_to(b + 10); gap_len = 8'd40;
    expect_go("R9 mid-gap change ignored", b + 96);
    finish_tx(b2);
    tx_pend = 1'b1;
    expect_go("R9 next gap uses new value", b2 + 40);
    finish_tx(b2);

    fresh(8'd30, 8'd20, 1'b0, 1'b0, b);
    run_to(b + 40); repeat (3) cyc();
    tx_pend = 1'b1;
    expect_go("R11 ready then request", tcnt);
    finish_tx(b2);
    run_to(b2 + 40);
    crs = 1'b1; cyc(); cyc();
    tx_pend = 1'b1; repeat (3) cyc();
    crs = 1'b0; cyc(); b = tcnt;
    expect_go("R11 carrier while ready", b + 30);
    finish_tx(b2);

    fresh(8'd30, 8'd20, 1'b0, 1'b1, b);
    expect_go("R10 first go", b + 30);
    check_bit("R10 go single cycle", tx_go, 1'b0);
    repeat (100) cyc();
    tx_busy = 1'b1; repeat (3) cyc();
    tx_busy = 1'b0; cyc(); cyc(); b2 = tcnt;
    expect_go("R10 gap after busy release", b2 + 30);
    finish_tx(b2);

    fresh(8'd96, 8'd60, 1'b0, 1'b1, b);
    eg = b + 96;
    expect_go("R8 go before collision", eg);
    push_ev("R8 backoff timing", 1, eg + 96);
    tx_busy = 1'b1; repeat (3) cyc();
    col = 1'b1; repeat (2) cyc(); col = 1'b0;
    run_to(eg + 64);
    check_bit("R8 jam not before preamble end", jam_on, 1'b0);
    cyc();
    check_bit("R8 jam after preamble", jam_on, 1'b1);
    run_to(eg + 96);
    check_bit("R8 jam held", jam_on, 1'b1);
    cyc();
    check_bit("R8 jam ended", jam_on, 1'b0);
    tx_busy = 1'b0; cyc(); b2 = tcnt;
    expect_go("R8 retry after backoff", b2 + 96);
    finish_tx(b2);
    repeat (5) cyc();

    checks++;
    if (qk.size() != 0) begin
      fails++;
      $display("FAIL R2 missing events: got %0d left over, expected 0", qk.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule